// File: doc/BRIEF.md
# Input-Capture Timer

This block is a 16-bit up-counter that timestamps external events. A divider derived from the bus clock sets how fast the counter advances. The counter runs from zero up to a programmable limit, then wraps back to zero. Each wrap raises an overflow flag.

Two capture channels watch one input pin each. A channel first synchronises its pin into the clock domain. When it sees the edge kind selected for it, it copies the current count into its capture register and raises its flag. If the channel's interrupt enable is set, the flag also drives that channel's interrupt request.

Software reaches every field through a byte-wide register file. The file uses a plain synchronous write strobe, and reads are combinational on the address.

Top module: `capture_timer`

## Requirements
- R1: Register map, one byte per address. 0 = control. 1/2 = count high/low. 3/4 = limit high/low. 5/6/7 = channel 0 status, capture high, capture low. 8/9/10 = the same three for channel 1. Reads are combinational on the address. Unmapped addresses (11 to 15) read 0x00. Limit bytes are read/write.
- R2: After reset the count reads 0x0000, the limit reads 0xFFFF, and the control byte and both status bytes read 0x00. Both interrupt requests are low.
- R3: Control bits [2:0] select k. A 6-bit divider counts every clock from 0 after reset. The count advances on every clock where the low k bits of the divider are all ones, so once every 2^k clocks for k = 0 to 6. Value 7 acts as 6. Control bits [6:3] read 0.
- R4: On an advance where the count equals the limit, the count becomes 0 and control bit 7 (overflow flag) is set.
- R5: Writing the control byte with bit 7 = 0 clears the overflow flag. Writing it with bit 7 = 1 leaves the flag unchanged. A wrap in the same cycle as a clearing write wins.
- R6: Status bits [3:2] choose the capture edge: 00 = none, 01 = rising, 10 = falling, 11 = both.
- R7: A pin level change first sampled at rising edge n is detected after two synchroniser stages. At edge n+2 the capture register takes the count visible just before that edge.
- R8: Status bit 7 is the channel flag. A capture sets it. Writing the status byte with bit 7 = 0 clears it. Writing it with bit 7 = 1 has no effect on it. A capture wins over a same-cycle clear.
- R9: The interrupt request of a channel is high exactly while its flag and its enable (status bit 6) are both set.
- R10: Status bits 5 and 4 are stored mode bits. Channel 0 stores both. Channel 1 has no bit 5: it reads 0 whatever is written. Status bits [1:0] read 0.
- R11: Writes to the count bytes and to the capture bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cap_pin | input | 2 | Asynchronous capture inputs, one per channel |
| irq | output | 2 | Interrupt request per channel |

## Verification
The assertions check the following on every cycle:
- the count holds between divider ticks and steps by one on a tick;
- the wrap returns the count to zero and sets the overflow flag;
- both sticky flags stay set unless a clearing write arrives;
- a capture stores the count of the detecting cycle and sets its flag;
- channel 1's missing mode bit reads zero.

The bench scenarios show the remaining behaviour. This includes the exact pin-to-capture latency through the synchroniser, and each edge-select code rejecting the edges it should ignore. It also includes the divider phase for every select value, the reset contents, and writes to read-only registers leaving them untouched.

// File: rtl/tmr_pkg.sv
// Shared constants and types of the input-capture timer.
// Assumes a byte-wide register interface and a 16-bit count.
package tmr_pkg;
    localparam int BYTE_W      = 8;
    localparam int CNT_W       = 16;
    localparam int ADR_CTRL    = 0;
    localparam int ADR_CNT_HI  = 1;
    localparam int ADR_CNT_LO  = 2;
    localparam int ADR_LIM_HI  = 3;
    localparam int ADR_LIM_LO  = 4;
    localparam int ADR_CH_BASE = 5;
    localparam int CH_STRIDE   = 3;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    // Per-channel configuration, laid out as status bits [6:2].
    typedef struct packed {
        logic      irq_en;
        logic      mode_hi;
        logic      mode_lo;
        edge_sel_e edge_sel;
    } ch_cfg_t;

    // Build the status byte a channel presents on a read.
    function automatic logic [BYTE_W-1:0] pack_status(input logic flag, input ch_cfg_t cfg);
        return {flag, cfg, 2'b00};
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Clock divider of the timer: emits a one-cycle tick every 2^k clocks.
// k comes from the select input; selects above DIV_LOG2_MAX saturate.
// Assumes the divider runs freely from reset and is never reloaded.
module tmr_prescaler #(
    parameter int SEL_W        = 3,
    parameter int DIV_LOG2_MAX = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [DIV_LOG2_MAX-1:0] div_q;
    logic [SEL_W-1:0]        sel_eff;
    logic [DIV_LOG2_MAX-1:0] mask;

    // Saturate the select to the deepest divider stage.
    always_comb sel_eff = (int'(sel) > DIV_LOG2_MAX) ? SEL_W'(DIV_LOG2_MAX) : sel;

    // Low sel_eff bits of the divider must all be ones for a tick.
    always_comb mask = ~({DIV_LOG2_MAX{1'b1}} << sel_eff);

    // Tick when the masked divider bits are saturated.
    always_comb tick = ((div_q & mask) == mask);

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + DIV_LOG2_MAX'(1);
    end
endmodule

// File: rtl/tmr_counter.sv
// Modulo up-counter: advances on each tick and returns to zero on the
// tick after it matches the limit. wrap marks that returning tick.
// Assumes tick is a single-cycle enable from the divider.
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         wrap
);
    // A wrap is a tick taken while sitting on the limit.
    always_comb wrap = tick && (count == limit);

    // Count register with modulo return.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (wrap) count <= '0;
        else if (tick) count <= count + W'(1);
    end
endmodule

// File: rtl/tmr_capture_ch.sv
// One capture channel: synchroniser, edge detector, configuration byte,
// sticky flag and capture register. Assumes SYNC_STAGES >= 2 and that
// the capture register needs no reset value (read only after a capture).
module tmr_capture_ch
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_MODE_HI = 1'b1,
    parameter int W           = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  logic [W-1:0]      count,
    input  logic              cfg_we,
    input  logic              flag_keep,
    input  ch_cfg_t           cfg_wr,
    output logic [BYTE_W-1:0] status,
    output logic [W-1:0]      cap_val,
    output logic              flag,
    output logic              irq_en,
    output logic              cap_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_out;
    logic                   prev_q;
    logic                   rise;
    logic                   fall;
    ch_cfg_t                cfg_q;
    ch_cfg_t                cfg_d;

    // Synchroniser chain; the newest sample enters at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign sync_out = sync_q[SYNC_STAGES-1];

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_out;
    end

    // Edge classification in the clock domain.
    always_comb begin
        rise = sync_out & ~prev_q;
        fall = ~sync_out & prev_q;
    end

    // Pick the edges that count as captures.
    always_comb begin
        unique case (cfg_q.edge_sel)
            EDGE_RISE: cap_evt = rise;
            EDGE_FALL: cap_evt = fall;
            EDGE_ANY:  cap_evt = rise | fall;
            default:   cap_evt = 1'b0;
        endcase
    end

    // Next configuration, with the upper mode bit tied off when absent.
    generate
        if (HAS_MODE_HI) begin : g_mode_hi
            always_comb cfg_d = cfg_we ? cfg_wr : cfg_q;
        end else begin : g_no_mode_hi
            always_comb begin
                cfg_d         = cfg_we ? cfg_wr : cfg_q;
                cfg_d.mode_hi = 1'b0;
            end
        end
    endgenerate

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= ch_cfg_t'(0);
        else        cfg_q <= cfg_d;
    end

    // Sticky flag: a capture beats a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag <= 1'b0;
        else if (cap_evt)             flag <= 1'b1;
        else if (cfg_we && !flag_keep) flag <= 1'b0;
    end

    // Capture register, loaded only on an accepted edge.
    always_ff @(posedge clk) begin
        if (cap_evt) cap_val <= count;
    end

    // Read view and enable output.
    always_comb begin
        status = pack_status(flag, cfg_q);
        irq_en = cfg_q.irq_en;
    end
endmodule

// File: rtl/capture_timer.sv
// Top of the input-capture timer: byte register file, divider, modulo
// counter and N_CH capture channels. Assumes a single clock and that
// PS_SEL_W leaves room for the overflow flag in the control byte.
module capture_timer
    import tmr_pkg::*;
#(
    parameter int              N_CH            = 2,
    parameter int              ADDR_W          = 4,
    parameter int              SYNC_STAGES     = 2,
    parameter int              PS_SEL_W        = 3,
    parameter int              DIV_LOG2_MAX    = 6,
    parameter logic [N_CH-1:0] MODE_HI_PRESENT = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   cap_pin,
    output logic [N_CH-1:0]   irq
);
    localparam int CTRL_PAD = BYTE_W - 1 - PS_SEL_W;

    logic [PS_SEL_W-1:0]           ps_sel_q;
    logic                          ovf_q;
    logic [CNT_W-1:0]              lim_q;
    logic [CNT_W-1:0]              cnt_q;
    logic                          tick;
    logic                          wrap;
    logic                          ctrl_we;
    logic                          lim_hi_we;
    logic                          lim_lo_we;
    logic [N_CH-1:0]               ch_we;
    logic [N_CH-1:0]               ch_flag;
    logic [N_CH-1:0]               ch_ie;
    logic [N_CH-1:0]               cap_evt;
    logic [N_CH-1:0][BYTE_W-1:0]   ch_status;
    logic [N_CH-1:0][CNT_W-1:0]    cap_val;

    // Write decode for the shared registers.
    always_comb begin
        ctrl_we   = bus_wr && (int'(bus_addr) == ADR_CTRL);
        lim_hi_we = bus_wr && (int'(bus_addr) == ADR_LIM_HI);
        lim_lo_we = bus_wr && (int'(bus_addr) == ADR_LIM_LO);
    end

    // Control register: divider select and overflow flag (wrap wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_sel_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (ctrl_we) ps_sel_q <= bus_wdata[PS_SEL_W-1:0];
            if (wrap)                         ovf_q <= 1'b1;
            else if (ctrl_we && !bus_wdata[7]) ovf_q <= 1'b0;
        end
    end

    // Limit register, full range after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '1;
        end else begin
            if (lim_hi_we) lim_q[CNT_W-1:BYTE_W] <= bus_wdata;
            if (lim_lo_we) lim_q[BYTE_W-1:0]     <= bus_wdata;
        end
    end

    tmr_prescaler #(
        .SEL_W        (PS_SEL_W),
        .DIV_LOG2_MAX (DIV_LOG2_MAX)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ps_sel_q),
        .tick  (tick)
    );

    tmr_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .limit (lim_q),
        .count (cnt_q),
        .wrap  (wrap)
    );

    // One channel per capture pin.
    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            assign ch_we[i] = bus_wr && (int'(bus_addr) == ADR_CH_BASE + CH_STRIDE * i);

            tmr_capture_ch #(
                .SYNC_STAGES (SYNC_STAGES),
                .HAS_MODE_HI (MODE_HI_PRESENT[i]),
                .W           (CNT_W)
            ) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin       (cap_pin[i]),
                .count     (cnt_q),
                .cfg_we    (ch_we[i]),
                .flag_keep (bus_wdata[7]),
                .cfg_wr    (ch_cfg_t'(bus_wdata[6:2])),
                .status    (ch_status[i]),
                .cap_val   (cap_val[i]),
                .flag      (ch_flag[i]),
                .irq_en    (ch_ie[i]),
                .cap_evt   (cap_evt[i])
            );
        end
    endgenerate

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            ADR_CTRL:   bus_rdata = {ovf_q, {CTRL_PAD{1'b0}}, ps_sel_q};
            ADR_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
            ADR_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
            ADR_LIM_HI: bus_rdata = lim_q[CNT_W-1:BYTE_W];
            ADR_LIM_LO: bus_rdata = lim_q[BYTE_W-1:0];
            default:    bus_rdata = '0;
        endcase
        for (int i = 0; i < N_CH; i++) begin
            if (int'(bus_addr) == ADR_CH_BASE + CH_STRIDE * i)
                bus_rdata = ch_status[i];
            if (int'(bus_addr) == ADR_CH_BASE + CH_STRIDE * i + 1)
                bus_rdata = cap_val[i][CNT_W-1:BYTE_W];
            if (int'(bus_addr) == ADR_CH_BASE + CH_STRIDE * i + 2)
                bus_rdata = cap_val[i][BYTE_W-1:0];
        end
    end

    // Interrupt requests gated by the per-channel enables.
    assign irq = ch_flag & ch_ie;
endmodule

// File: rtl/tmr_checker.sv
// Property checker for capture_timer, attached by the bind below.
// Observes the divider tick, count, flags and bus; drives nothing.
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int              N_CH            = 2,
    parameter int              ADDR_W          = 4,
    parameter logic [N_CH-1:0] MODE_HI_PRESENT = 2'b01
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick,
    input logic                       ovf,
    input logic [CNT_W-1:0]           cnt,
    input logic [CNT_W-1:0]           limit,
    input logic [N_CH-1:0]            cap_evt,
    input logic [N_CH-1:0]            flag,
    input logic [N_CH-1:0]            irq,
    input logic [N_CH-1:0][CNT_W-1:0] cap_val,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_wr,
    input logic [BYTE_W-1:0]          bus_wdata,
    input logic [BYTE_W-1:0]          bus_rdata
);
    // R3: without a tick the count does not move.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)) else $error("count moved without tick");

    // R3: a tick below the limit advances by exactly one.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != limit) |=> (cnt == $past(cnt) + 16'd1)) else $error("bad step");

    // R4: a tick on the limit returns to zero and flags overflow.
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == limit) |=> (cnt == '0 && ovf)) else $error("bad wrap");

    // R5: overflow flag persists unless cleared by a zero write.
    p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(bus_wr && int'(bus_addr) == ADR_CTRL && !bus_wdata[7])) |=> ovf)
        else $error("overflow flag dropped");

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            // R7: capture stores the count of the detecting cycle.
            p_cap_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
                cap_evt[i] |=> (cap_val[i] == $past(cnt) && flag[i]))
                else $error("capture value mismatch");

            // R8: channel flag persists unless cleared by a zero write.
            p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (flag[i] && !(bus_wr && int'(bus_addr) == ADR_CH_BASE + CH_STRIDE * i
                              && !bus_wdata[7])) |=> flag[i])
                else $error("channel flag dropped");

            // R8: a flag only rises after a capture event.
            p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag[i]) |-> $past(cap_evt[i])) else $error("flag rose without capture");

            // R9: a request needs a raised flag.
            p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
                irq[i] |-> flag[i]) else $error("request without flag");

            if (!MODE_HI_PRESENT[i]) begin : g_no_mode_hi
                // R10: the absent mode bit always reads zero.
                p_mode_hi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
                    (int'(bus_addr) == ADR_CH_BASE + CH_STRIDE * i) |-> !bus_rdata[5])
                    else $error("absent mode bit read as one");
            end
        end
    endgenerate
endmodule

bind capture_timer tmr_checker #(
    .N_CH            (N_CH),
    .ADDR_W          (ADDR_W),
    .MODE_HI_PRESENT (MODE_HI_PRESENT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ovf       (ovf_q),
    .cnt       (cnt_q),
    .limit     (lim_q),
    .cap_evt   (cap_evt),
    .flag      (ch_flag),
    .irq       (irq),
    .cap_val   (cap_val),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
);

// File: tb/tb_capture_timer.sv
// Bench for capture_timer: a cycle model built from the requirements is
// compared on every register and request after each clock, under directed
// corner cases followed by seeded random traffic.
module tb_capture_timer;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [1:0] pin = '0;
    logic [7:0] rdata;
    logic [1:0] irq;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    capture_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .cap_pin   (pin),
        .irq       (irq)
    );

    // Model state
    logic [5:0]  m_div;
    logic [2:0]  m_ps;
    logic        m_ovf;
    logic [15:0] m_cnt, m_lim;
    logic [1:0]  m_flag, m_ie, m_mh, m_ml, m_capok;
    logic [1:0]  m_es [2];
    logic [15:0] m_cap [2];
    logic [1:0]  m_s1, m_s2, m_prev;

    always @(posedge clk) begin : model
        int   eff, mask, base;
        logic tk, wp, ri, fa, hit;
        if (!rst_n) begin
            m_div <= '0; m_ps <= '0; m_ovf <= 1'b0; m_cnt <= '0; m_lim <= 16'hFFFF;
            m_flag <= '0; m_ie <= '0; m_mh <= '0; m_ml <= '0; m_capok <= '0;
            m_es[0] <= '0; m_es[1] <= '0; m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
        end else begin
            eff  = (m_ps > 3'd6) ? 6 : int'(m_ps);
            mask = (1 << eff) - 1;
            tk   = ((int'(m_div) & mask) == mask);
            wp   = tk && (m_cnt == m_lim);
            m_div <= m_div + 6'd1;
            if (wp)      m_cnt <= '0;
            else if (tk) m_cnt <= m_cnt + 16'd1;
            if (wp) m_ovf <= 1'b1;
            else if (wr && addr == 4'd0 && !wdata[7]) m_ovf <= 1'b0;
            if (wr && addr == 4'd0) m_ps <= wdata[2:0];
            if (wr && addr == 4'd3) m_lim[15:8] <= wdata;
            if (wr && addr == 4'd4) m_lim[7:0] <= wdata;
            for (int i = 0; i < 2; i++) begin
                base = 5 + 3 * i;
                ri = m_s2[i] && !m_prev[i];
                fa = !m_s2[i] && m_prev[i];
                case (m_es[i])
                    2'd1:    hit = ri;
                    2'd2:    hit = fa;
                    2'd3:    hit = ri || fa;
                    default: hit = 1'b0;
                endcase
                if (hit) begin
                    m_cap[i] <= m_cnt; m_capok[i] <= 1'b1; m_flag[i] <= 1'b1;
                end else if (wr && int'(addr) == base && !wdata[7]) begin
                    m_flag[i] <= 1'b0;
                end
                if (wr && int'(addr) == base) begin
                    m_ie[i] <= wdata[6];
                    m_mh[i] <= (i == 0) ? wdata[5] : 1'b0;
                    m_ml[i] <= wdata[4];
                    m_es[i] <= wdata[3:2];
                end
            end
            m_s1 <= pin; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    function automatic logic [7:0] exp_rd(input int a);
        case (a)
            0:  return {m_ovf, 4'b0000, m_ps};
            1:  return m_cnt[15:8];
            2:  return m_cnt[7:0];
            3:  return m_lim[15:8];
            4:  return m_lim[7:0];
            5:  return {m_flag[0], m_ie[0], m_mh[0], m_ml[0], m_es[0], 2'b00};
            6:  return m_cap[0][15:8];
            7:  return m_cap[0][7:0];
            8:  return {m_flag[1], m_ie[1], m_mh[1], m_ml[1], m_es[1], 2'b00};
            9:  return m_cap[1][15:8];
            10: return m_cap[1][7:0];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string addr_tag(input int a);
        case (a)
            0:          return "R5";
            1, 2:       return "R3";
            5, 8:       return "R8";
            6, 7, 9, 10: return "R7";
            default:    return "R1";
        endcase
    endfunction

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag, input int a);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, act, exp);
        end
    endtask

    // Sweep every address and the requests against the model.
    task automatic check_all(input string tag);
        wr = 1'b0;
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a);
            #0.5;
            if (((a == 6 || a == 7) && !m_capok[0]) || ((a == 9 || a == 10) && !m_capok[1]))
                continue;
            check8(rdata, exp_rd(a), (tag == "") ? addr_tag(a) : tag, a);
        end
        check8({6'b0, irq}, {6'b0, m_flag & m_ie}, (tag == "") ? "R9" : tag, 99);
    endtask

    task automatic cyc(input logic [3:0] a, input logic w, input logic [7:0] d,
                       input logic [1:0] p, input string tag);
        @(negedge clk);
        check_all(tag);
        addr = a; wr = w; wdata = d; pin = p;
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(4'd0, 1'b0, 8'h00, pin, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_all("R2");
        rst_n = 1'b1;
        // R4: small limit at full speed
        cyc(4'd3, 1'b1, 8'h00, 2'b00, "R2");
        cyc(4'd4, 1'b1, 8'h05, 2'b00, "R1");
        cyc(4'd0, 1'b1, 8'h00, 2'b00, "R1");
        idle(20, "R4");
        // R5: set-only and clearing writes to the overflow flag
        cyc(4'd3, 1'b1, 8'hFF, 2'b00, "R4");
        cyc(4'd4, 1'b1, 8'hFF, 2'b00, "R5");
        cyc(4'd0, 1'b1, 8'h80, 2'b00, "R5");
        idle(2, "R5");
        cyc(4'd0, 1'b1, 8'h00, 2'b00, "R5");
        idle(2, "R5");
        // R3: every divider select
        for (int s = 0; s < 8; s++) begin
            cyc(4'd0, 1'b1, 8'(s), 2'b00, "R3");
            idle(150, "R3");
        end
        cyc(4'd0, 1'b1, 8'h00, 2'b00, "R3");
        // R6 R7 R9: channel 0 rising only, enabled
        cyc(4'd5, 1'b1, 8'h44, 2'b00, "R6");
        cyc(4'd0, 1'b0, 8'h00, 2'b01, "R7");
        idle(5, "R7");
        cyc(4'd0, 1'b0, 8'h00, 2'b00, "R6");
        idle(5, "R9");
        // R8: writing one keeps the flag, writing zero clears it
        cyc(4'd5, 1'b1, 8'hC4, pin, "R8");
        idle(2, "R8");
        cyc(4'd5, 1'b1, 8'h44, pin, "R8");
        idle(2, "R9");
        // R6: falling only, then disabled
        cyc(4'd5, 1'b1, 8'h48, 2'b00, "R6");
        cyc(4'd0, 1'b0, 8'h00, 2'b01, "R6");
        idle(5, "R6");
        cyc(4'd0, 1'b0, 8'h00, 2'b00, "R6");
        idle(5, "R7");
        cyc(4'd5, 1'b1, 8'h40, 2'b00, "R6");
        cyc(4'd0, 1'b0, 8'h00, 2'b01, "R6");
        idle(5, "R6");
        cyc(4'd0, 1'b0, 8'h00, 2'b00, "R6");
        idle(5, "R6");
        // R6: channel 1 on both edges
        cyc(4'd8, 1'b1, 8'h4C, 2'b00, "R6");
        cyc(4'd0, 1'b0, 8'h00, 2'b10, "R6");
        idle(5, "R7");
        cyc(4'd8, 1'b1, 8'h4C, 2'b10, "R8");
        cyc(4'd0, 1'b0, 8'h00, 2'b00, "R6");
        idle(5, "R9");
        // R10: absent mode bit on channel 1, present on channel 0
        cyc(4'd8, 1'b1, 8'hFF, pin, "R10");
        idle(2, "R10");
        cyc(4'd5, 1'b1, 8'hFF, pin, "R10");
        idle(2, "R10");
        // R11: read-only count and capture bytes
        cyc(4'd1, 1'b1, 8'hAA, pin, "R11");
        cyc(4'd2, 1'b1, 8'h55, pin, "R11");
        cyc(4'd6, 1'b1, 8'h33, pin, "R11");
        cyc(4'd10, 1'b1, 8'hCC, pin, "R11");
        idle(2, "R11");
        // Random traffic, tagged per address
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] p;
            p = pin;
            for (int c = 0; c < 2; c++) if (($urandom % 8) == 0) p[c] = ~p[c];
            cyc(4'($urandom % 16), (($urandom % 6) == 0), 8'($urandom), p, "");
        end
        @(negedge clk);
        check_all("");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule